// File: doc/BRIEF.md
# Transmit Descriptor Handshake Engine

This block is the device half of a one-slot transmit handshake between a host and a network transmitter. The host places a four-word descriptor in shared word-addressed memory and raises a one-cycle poll strobe. The engine reads the descriptor's status word and acts only if the host has handed it over. It then reads the control word and the buffer pointer, checks the length, and fetches the buffer one 32-bit word at a time. The bytes leave on a valid/ready byte stream. Last, it writes the status word back with the ownership bit cleared.

When the control word marks the buffer as a setup packet, no byte reaches the stream. Each 4-byte group of the buffer instead becomes one 16-bit write on an address-filter load port. Once a descriptor is finished, the descriptor pointer moves on by four words, or goes back to the ring base when the end-of-ring flag is set. A poll that arrives while the engine is busy is held and served as soon as the current descriptor is done.

The byte stream follows the usual rules. A byte moves on any cycle in which `tx_valid_o` and `tx_ready_i` are both high. While `tx_valid_o` is high and `tx_ready_i` is low, the data and both marker bits stay stable. The engine never withdraws a byte it has offered. The consumer can hold `tx_ready_i` low for as long as it needs, and the engine simply waits. The filter load port and the memory port have no back-pressure of their own beyond the memory acknowledge.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, `mem_req_o`, `tx_valid_o`, `filt_we_o` and `busy_o` are all low.
- R2: A poll makes the engine read the status word at the descriptor pointer, which starts at `ring_base_i`. If bit 31 of that word is clear, the engine goes idle with no writeback, no stream output and no pointer change, so a later poll reads the same descriptor.
- R3: For an owned descriptor whose length (control bits 10:0) is between 1 and MAX_LEN, exactly that many bytes are streamed in address order from the buffer. The buffer byte address is held in word 2; the engine uses bits ADDR_W+1:2 of it. Byte 0 of each memory word is bits 7:0.
- R4: `tx_first_o` is high on the first byte only when control bit 29 is set. `tx_last_o` is high on the final byte only when control bit 30 is set.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o`, `tx_first_o` and `tx_last_o` hold their values.
- R6: A descriptor that completes without error gets 32'h7FFF_FFFF written to its status word.
- R7: A length of zero, or a length above MAX_LEN, streams nothing. The status word is written back as 32'h0000_8000, which has the error summary bit 15 set and the ownership bit clear.
- R8: With control bit 27 set and length SETUP_LEN (192), nothing is streamed. Instead there are 48 filter writes, where write k carries index k and the low 16 bits of buffer word k; success is then written back. A setup descriptor with any other length is treated as in R7.
- R9: After a writeback, the pointer goes to `ring_base_i` if control bit 25 was set, and otherwise to the current pointer plus 4 words.
- R10: A poll that arrives while `busy_o` is high is kept. The next descriptor is fetched right after the current writeback, with no further poll.
- R11: A memory request holds `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` steady until `mem_ack_i` arrives. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | One-cycle poll-demand strobe |
| ring_base_i | input | ADDR_W | Word address of the descriptor ring |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream consumer ready |
| tx_data_o | output | 8 | Stream byte |
| tx_first_o | output | 1 | First byte of a first segment |
| tx_last_o | output | 1 | Final byte of a last segment |
| filt_we_o | output | 1 | Address-filter load strobe |
| filt_idx_o | output | FIDX_W | Address-filter word index |
| filt_word_o | output | 16 | Address-filter word |
| busy_o | output | 1 | Engine active or poll pending |

## Verification
A wrong byte counter shows up at once as a short or long frame, or as a misplaced last marker, and it also corrupts the next buffer word fetch address on the memory port. A bad descriptor pointer does not show until the following poll reads the wrong word, so the ring tests chain several descriptors with and without the end-of-ring flag. A mistake in the setup or error decode shows up in the same descriptor, either as bytes leaking onto the stream or as the wrong status code written back. Lengths are swept across every word-alignment residue while the consumer applies stalls.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OWN_BIT = 31;
  localparam int LS_BIT  = 30;
  localparam int FS_BIT  = 29;
  localparam int SET_BIT = 27;
  localparam int EOR_BIT = 25;
  localparam logic [31:0] WB_OK  = 32'h7FFF_FFFF;
  localparam logic [31:0] WB_ERR = 32'h0000_8000;

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_CTRL, S_BUFA, S_FETCH, S_SEND, S_FILT, S_WB
  } txd_state_e;

  typedef struct packed {
    logic first;
    logic last;
    logic setup;
    logic eor;
  } txd_flags_t;
endpackage

// File: rtl/txd_decode.sv
module txd_decode
  import txd_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MAX_LEN   = 1536,
  parameter int SETUP_LEN = 192
) (
  input  logic [31:0]      ctrl_i,
  output txd_flags_t       flags_o,
  output logic [LEN_W-1:0] len_o,
  output logic             len_bad_o
);
  localparam logic [LEN_W:0] MAX_L = (LEN_W+1)'(MAX_LEN);
  localparam logic [LEN_W:0] SET_L = (LEN_W+1)'(SETUP_LEN);

  logic [LEN_W:0] len_x;
  logic unused_ctrl;

  assign len_o = ctrl_i[LEN_W-1:0];
  assign len_x = {1'b0, ctrl_i[LEN_W-1:0]};

  assign flags_o.first = ctrl_i[FS_BIT];
  assign flags_o.last  = ctrl_i[LS_BIT];
  assign flags_o.setup = ctrl_i[SET_BIT];
  assign flags_o.eor   = ctrl_i[EOR_BIT];

  always_comb begin
    len_bad_o = 1'b0;
    if (len_x == '0) len_bad_o = 1'b1;
    if (len_x > MAX_L) len_bad_o = 1'b1;
    if (ctrl_i[SET_BIT] && (len_x != SET_L)) len_bad_o = 1'b1;
  end

  assign unused_ctrl = ^{ctrl_i[31], ctrl_i[28], ctrl_i[26], ctrl_i[24:LEN_W]};
endmodule

// File: rtl/txd_lane.sv
module txd_lane #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [7:0]         byte_o
);
  logic [7:0] lane_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_arr[g] = word_i[8*g +: 8];
  end

  assign byte_o = lane_arr[sel_i];
endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int ADDR_W    = 16,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic              advance_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] cur_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_WORDS);

  logic [ADDR_W-1:0] ptr_q;
  logic              loaded_q;

  assign cur_o = loaded_q ? ptr_q : ring_base_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      loaded_q <= 1'b0;
    end else if (advance_i) begin
      loaded_q <= 1'b1;
      ptr_q    <= wrap_i ? ring_base_i : cur_o + STEP;
    end
  end
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 11,
  parameter int MAX_LEN   = 1536,
  parameter int SETUP_LEN = 192,
  localparam int FIDX_W   = $clog2(SETUP_LEN / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_first_o,
  output logic              tx_last_o,
  output logic              filt_we_o,
  output logic [FIDX_W-1:0] filt_idx_o,
  output logic [15:0]       filt_word_o,
  output logic              busy_o
);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] FOUR = LEN_W'(4);

  txd_state_e        state_q;
  logic [31:0]       ctrl_q;
  logic [31:0]       word_q;
  logic [ADDR_W-1:0] buf_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              err_q;
  logic              pend_q;

  txd_flags_t        flags;
  logic [LEN_W-1:0]  len;
  logic              len_bad;
  logic [ADDR_W-1:0] desc_ptr;
  logic              advance;
  logic              byte_done;
  logic              frame_end;
  logic              filt_end;

  txd_decode #(
    .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .SETUP_LEN(SETUP_LEN)
  ) u_dec (
    .ctrl_i(ctrl_q), .flags_o(flags), .len_o(len), .len_bad_o(len_bad)
  );

  txd_lane #(.LANES(4)) u_lane (
    .word_i(word_q), .sel_i(cnt_q[1:0]), .byte_o(tx_data_o)
  );

  txd_ring_ptr #(.ADDR_W(ADDR_W), .DESC_WORDS(4)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base_i),
    .advance_i(advance), .wrap_i(flags.eor), .cur_o(desc_ptr)
  );

  // Memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_ptr;
    mem_wdata_o = err_q ? WB_ERR : WB_OK;
    unique case (state_q)
      S_STAT:  mem_req_o = 1'b1;
      S_CTRL:  begin mem_req_o = 1'b1; mem_addr_o = desc_ptr + ADDR_W'(1); end
      S_BUFA:  begin mem_req_o = 1'b1; mem_addr_o = desc_ptr + ADDR_W'(2); end
      S_FETCH: begin mem_req_o = 1'b1; mem_addr_o = buf_q + ADDR_W'(cnt_q >> 2); end
      S_WB:    begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  // Byte stream and filter port
  assign tx_valid_o  = (state_q == S_SEND);
  assign tx_first_o  = tx_valid_o && flags.first && (cnt_q == '0);
  assign tx_last_o   = tx_valid_o && flags.last && frame_end;
  assign filt_we_o   = (state_q == S_FILT);
  assign filt_idx_o  = cnt_q[FIDX_W+1:2];
  assign filt_word_o = word_q[15:0];
  assign busy_o      = (state_q != S_IDLE) || pend_q;

  assign frame_end = (cnt_q == len - ONE);
  assign byte_done = tx_valid_o && tx_ready_i;
  assign filt_end  = ((cnt_q + FOUR) == len);
  assign advance   = (state_q == S_WB) && mem_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      word_q  <= '0;
      buf_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (state_q == S_IDLE) pend_q <= 1'b0;
      else if (poll_i)       pend_q <= 1'b1;

      unique case (state_q)
        S_IDLE: if (poll_i || pend_q) state_q <= S_STAT;
        S_STAT: if (mem_ack_i) state_q <= mem_rdata_i[OWN_BIT] ? S_CTRL : S_IDLE;
        S_CTRL: if (mem_ack_i) begin
          ctrl_q  <= mem_rdata_i;
          state_q <= S_BUFA;
        end
        S_BUFA: if (mem_ack_i) begin
          buf_q   <= mem_rdata_i[ADDR_W+1:2];
          cnt_q   <= '0;
          err_q   <= len_bad;
          state_q <= len_bad ? S_WB : S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          state_q <= flags.setup ? S_FILT : S_SEND;
        end
        S_SEND: if (byte_done) begin
          cnt_q <= cnt_q + ONE;
          if (frame_end)               state_q <= S_WB;
          else if (cnt_q[1:0] == 2'd3) state_q <= S_FETCH;
        end
        S_FILT: begin
          cnt_q   <= cnt_q + FOUR;
          state_q <= filt_end ? S_WB : S_FETCH;
        end
        S_WB: if (mem_ack_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_engine_chk.sv
module txdesc_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_first_o,
  input logic              tx_last_o,
  input logic              filt_we_o,
  input logic              busy_o
);
  // R11: request fields stay put until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  // R6 / R7: only the two status codes are ever written, both with ownership cleared
  p_wb_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> (mem_wdata_o == 32'h7FFF_FFFF || mem_wdata_o == 32'h0000_8000));

  // R5: an offered byte is held while stalled
  p_stream_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_first_o)
                                 && $stable(tx_last_o));

  // R8: a filter write never coincides with stream output or memory traffic
  p_setup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    filt_we_o |-> !tx_valid_o && !mem_req_o);

  // R10: any activity is reported as busy
  p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o || filt_we_o || mem_req_o) |-> busy_o);

  // R3: stream bytes and memory fetches alternate, never overlap
  p_stream_mem_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid_o, mem_req_o}));
endmodule

bind txdesc_engine txdesc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_first_o(tx_first_o), .tx_last_o(tx_last_o), .filt_we_o(filt_we_o),
  .busy_o(busy_o)
);

// File: tb/txdesc_engine_tb.sv
module txdesc_engine_tb;
  localparam int AW = 16;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] LSB = 32'h4000_0000;
  localparam logic [31:0] FSB = 32'h2000_0000;
  localparam logic [31:0] SET = 32'h0800_0000;
  localparam logic [31:0] EOR = 32'h0200_0000;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b1, tx_first, tx_last;
  logic [7:0] tx_data;
  logic filt_we, busy;
  logic [5:0] filt_idx;
  logic [15:0] filt_word;

  always #5 clk = ~clk;

  txdesc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .poll_i(poll), .ring_base_i(AW'(BASE)),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_first_o(tx_first), .tx_last_o(tx_last), .filt_we_o(filt_we),
    .filt_idx_o(filt_idx), .filt_word_o(filt_word), .busy_o(busy)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model, host write port and capture
  logic [31:0] mem [256];
  logic host_we = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_data = '0;
  logic cap_clr = 1'b0;
  int wr_cnt, ncap, nfilt, viol_mem, viol_str;
  logic [7:0] cap_d [512];
  logic cap_f [512];
  logic cap_l [512];
  logic [5:0] f_idx [64];
  logic [15:0] f_word [64];
  logic p_req, p_ack, p_we, p_val, p_rdy, p_first, p_last;
  logic [AW-1:0] p_addr;
  logic [7:0] p_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {pat(i*4+3), pat(i*4+2), pat(i*4+1), pat(i*4)};
      mem_ack <= 1'b0;
      wr_cnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end
      if (host_we) mem[host_addr] <= host_data;
    end
  end

  always @(posedge clk) begin
    if (!rst_n || cap_clr) begin
      ncap <= 0;
      nfilt <= 0;
    end else begin
      if (tx_valid && tx_ready) begin
        cap_d[ncap] <= tx_data;
        cap_f[ncap] <= tx_first;
        cap_l[ncap] <= tx_last;
        ncap <= ncap + 1;
      end
      if (filt_we) begin
        f_idx[nfilt] <= filt_idx;
        f_word[nfilt] <= filt_word;
        nfilt <= nfilt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      viol_mem <= 0; viol_str <= 0;
      p_req <= 1'b0; p_ack <= 1'b0; p_val <= 1'b0; p_rdy <= 1'b1;
      p_we <= 1'b0; p_addr <= '0; p_data <= '0; p_first <= 1'b0; p_last <= 1'b0;
    end else begin
      if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we))
        viol_mem <= viol_mem + 1;
      if (p_val && !p_rdy && (!tx_valid || tx_data != p_data || tx_first != p_first
                              || tx_last != p_last))
        viol_str <= viol_str + 1;
      p_req <= mem_req; p_ack <= mem_ack; p_addr <= mem_addr; p_we <= mem_we;
      p_val <= tx_valid; p_rdy <= tx_ready; p_data <= tx_data;
      p_first <= tx_first; p_last <= tx_last;
    end
  end

  int cyc = 0;
  int rdy_mode = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(int a, logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = 8'(a); host_data = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic set_desc(int dw, bit own, logic [31:0] ctrl, int bufw);
    host_wr(dw, own ? OWN : 32'h0);
    host_wr(dw + 1, ctrl);
    host_wr(dw + 2, 32'(bufw * 4));
    host_wr(dw + 3, 32'h0);
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // compare captured bytes [from, from+len) against buffer word bufw
  task automatic cmp_bytes(int from, int len, int bufw, bit fs, bit ls, string tag);
    int bad = 0;
    int bad_fl = 0;
    for (int i = 0; i < len; i++) begin
      if (cap_d[from+i] !== pat(bufw*4 + i)) bad++;
      if (cap_f[from+i] !== (fs && i == 0)) bad_fl++;
      if (cap_l[from+i] !== (ls && i == len-1)) bad_fl++;
    end
    check(bad == 0, {tag, " R3 byte order"}, bad, 0);
    check(bad_fl == 0, {tag, " R4 first/last marks"}, bad_fl, 0);
  endtask

  task automatic frame(int len, bit fs, bit ls, int bufw, string tag);
    logic [31:0] ctrl;
    ctrl = EOR | 32'(len) | (fs ? FSB : 32'h0) | (ls ? LSB : 32'h0);
    set_desc(BASE, 1'b1, ctrl, bufw);
    clear_cap();
    do_poll();
    wait_idle();
    check(ncap == len, {tag, " R3 byte count"}, ncap, len);
    cmp_bytes(0, len, bufw, fs, ls, tag);
    check(mem[BASE] == 32'h7FFF_FFFF, {tag, " R6 writeback"}, mem[BASE], 32'h7FFF_FFFF);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !tx_valid && !filt_we && !busy, "R1 reset state",
          {mem_req, tx_valid, filt_we, busy}, 0);

    // R2: descriptor not owned
    set_desc(BASE, 1'b0, EOR | 32'd8, 64);
    clear_cap();
    w0 = wr_cnt;
    do_poll();
    wait_idle();
    check(wr_cnt == w0, "R2 no writeback when not owned", wr_cnt, w0);
    check(ncap == 0, "R2 nothing streamed when not owned", ncap, 0);
    check(mem[BASE] == 32'h0, "R2 status untouched", mem[BASE], 0);
    // same descriptor is re-read after ownership is granted
    frame(5, 1'b1, 1'b1, 64, "R2 re-read");

    // length sweep over all alignments, with and without stalls
    for (int len = 1; len <= 24; len++) begin
      rdy_mode = len % 2;
      frame(len, len[0], len[1], 64 + (len % 5), $sformatf("len%0d", len));
    end
    rdy_mode = 1;

    // R7: bad lengths
    set_desc(BASE, 1'b1, EOR | FSB | LSB | 32'd0, 64);
    clear_cap(); do_poll(); wait_idle();
    check(ncap == 0, "R7 zero length streams nothing", ncap, 0);
    check(mem[BASE] == 32'h0000_8000, "R7 zero length error code", mem[BASE], 32'h8000);
    set_desc(BASE, 1'b1, EOR | 32'd1537, 64);
    clear_cap(); do_poll(); wait_idle();
    check(ncap == 0, "R7 oversize streams nothing", ncap, 0);
    check(mem[BASE] == 32'h0000_8000, "R7 oversize error code", mem[BASE], 32'h8000);

    // R8: setup packet
    set_desc(BASE, 1'b1, EOR | SET | 32'd192, 128);
    clear_cap(); do_poll(); wait_idle();
    check(ncap == 0, "R8 setup not streamed", ncap, 0);
    check(nfilt == 48, "R8 filter write count", nfilt, 48);
    begin
      int bad = 0;
      for (int k = 0; k < 48; k++)
        if (f_idx[k] != 6'(k) ||
            f_word[k] != {pat((128+k)*4+1), pat((128+k)*4)}) bad++;
      check(bad == 0, "R8 filter index and word", bad, 0);
    end
    check(mem[BASE] == 32'h7FFF_FFFF, "R8 setup writeback", mem[BASE], 32'h7FFF_FFFF);
    set_desc(BASE, 1'b1, EOR | SET | 32'd96, 128);
    clear_cap(); do_poll(); wait_idle();
    check(nfilt == 0 && ncap == 0, "R8 short setup produces nothing", nfilt + ncap, 0);
    check(mem[BASE] == 32'h0000_8000, "R8 short setup error code", mem[BASE], 32'h8000);

    // R9: ring advance and wrap
    set_desc(BASE, 1'b1, 32'd4, 64);
    set_desc(BASE + 4, 1'b1, EOR | 32'd4, 80);
    clear_cap(); do_poll(); wait_idle();
    do_poll(); wait_idle();
    check(ncap == 8, "R9 two frames", ncap, 8);
    cmp_bytes(0, 4, 64, 1'b0, 1'b0, "R9 slot0");
    cmp_bytes(4, 4, 80, 1'b0, 1'b0, "R9 slot1 at ptr+4");
    check(mem[BASE+4] == 32'h7FFF_FFFF, "R9 second slot writeback", mem[BASE+4], 32'h7FFF_FFFF);
    set_desc(BASE, 1'b1, EOR | 32'd4, 96);
    clear_cap(); do_poll(); wait_idle();
    check(ncap == 4, "R9 wrap count", ncap, 4);
    cmp_bytes(0, 4, 96, 1'b0, 1'b0, "R9 wrap to base");

    // R10: poll during busy is kept
    set_desc(BASE, 1'b1, 32'd8, 64);
    set_desc(BASE + 4, 1'b1, EOR | 32'd8, 72);
    clear_cap();
    do_poll();
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R10 busy while working", busy, 1);
    do_poll();
    wait_idle();
    check(ncap == 16, "R10 pending poll served", ncap, 16);
    cmp_bytes(0, 8, 64, 1'b0, 1'b0, "R10 first");
    cmp_bytes(8, 8, 72, 1'b0, 1'b0, "R10 second");

    check(viol_mem == 0, "R11 request held until ack", viol_mem, 0);
    check(viol_str == 0, "R5 stalled byte held", viol_str, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule